// File: doc/BRIEF.md
# Retransmit FIFO with Half-Full Flag

A single-clock first-in first-out buffer, 9 bits wide by default, whose depth is a power of two. Writes and reads are requested with active-low strobes that are sampled as enables on the rising clock edge. Three active-low flags report the fill level: empty, full, and a half-full flag that turns on only once the buffer holds more than half its capacity. An active-low asynchronous reset returns the buffer to empty.

An active-low rewind input moves the read pointer back to physical location zero. The buffer then replays every word written since the last reset, followed by any words written after the rewind. Occupancy is always the distance between the write and read pointers, so the flags follow the rewind at once. This gives a simple packet-resend path, provided that no more than one buffer depth of words has been written since reset.

Read data is registered. It appears, with a valid indication, in the cycle after an accepted read. At all other times the data port is parked at zero, which stands in for a high-impedance output.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the buffer is empty: `empty_no`=0, `full_no`=1, `half_no`=1, `rdata_oe_o`=0.
- R2: Words are read out in the order they were written. The word taken by an accepted read appears on `rdata_o` with `rdata_oe_o`=1 after the same clock edge.
- R3: A write strobe while the buffer is full is ignored: no word is stored and the write pointer holds, even when a read happens in the same cycle.
- R4: A read strobe while the buffer is empty is ignored. `rdata_oe_o` stays 0 and the read pointer holds, so a later read returns the next word written.
- R5: `full_no` is 0 exactly when occupancy equals the depth.
- R6: `half_no` is 0 exactly when occupancy is at least depth/2+1. At exactly depth/2 it is 1.
- R7: When read and write strobes are both low and the buffer is neither empty nor full, both operations take place and occupancy is unchanged.
- R8: `rt_ni` low at a clock edge sets the read pointer to location zero. Occupancy then equals the number of writes since reset, and the flags follow that value.
- R9: Words written after a rewind are delivered in order once the replayed words have been read.
- R10: `rdata_oe_o` is 1 only in the cycle after an accepted read. While it is 0, `rdata_o` reads 0.
- R11: During a rewind cycle the read and write strobes are ignored.
- R12: `empty_no` is 0 exactly when occupancy is zero. A combined read and write on an empty buffer performs only the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| rt_ni | input | 1 | Rewind read pointer to location zero, active low |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, zero when not enabled |
| rdata_oe_o | output | 1 | Read data valid / output enable |
| empty_no | output | 1 | Empty flag, active low |
| full_no | output | 1 | Full flag, active low |
| half_no | output | 1 | More-than-half-full flag, active low |

## Verification
The hardest case to reach is a rewind taken after the pointers have already moved through a mix of single, combined and ignored operations, followed by fresh writes. Only that sequence shows whether replay starts at location zero, whether the strobes in the rewind cycle are discarded, and whether new data lines up behind the replayed words. The stimulus table builds exactly that history from reset: a read on empty, a combined read and write, a drain, and a combined operation on empty, then a rewind with both strobes asserted. Directed sequences follow. They fill the buffer past the half mark, attempt a write while full both alone and paired with a read, drain it through the half boundary, and read it while empty.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;
  typedef struct packed {
    logic rewind;
    logic push;
    logic pop;
  } fifo_op_t;
endpackage

// File: rtl/rewind_fifo_ctrl.sv
module rewind_fifo_ctrl
  import rewind_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic          rt_ni,
  input  logic          empty_i,
  input  logic          full_i,
  output fifo_op_t      op_o,
  output logic [AW:0]   wptr_o,
  output logic [AW:0]   rptr_o
);
  logic [AW:0] wptr_q, rptr_q;

  // rewind wins over both strobes
  always_comb begin
    op_o.rewind = !rt_ni;
    op_o.push   = rt_ni && !wr_ni && !full_i;
    op_o.pop    = rt_ni && !rd_ni && !empty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (op_o.push) wptr_q <= wptr_q + 1'b1;
      if (op_o.rewind)   rptr_q <= '0;
      else if (op_o.pop) rptr_q <= rptr_q + 1'b1;
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i && !wr_ni) |=> (wptr_q == $past(wptr_q)));

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_i && !rd_ni && rt_ni) |=> (rptr_q == $past(rptr_q)));

  assert_rewind_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rt_ni |=> (rptr_q == '0));

  assert_rewind_holds_wptr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rt_ni |=> (wptr_q == $past(wptr_q)));
endmodule

// File: rtl/rewind_fifo_flags.sv
module rewind_fifo_flags #(
  parameter int AW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [AW:0] wptr_i,
  input  logic [AW:0] rptr_i,
  output logic [AW:0] occ_o,
  output logic        empty_no,
  output logic        full_no,
  output logic        half_no
);
  localparam int          DEPTH     = 1 << AW;
  localparam logic [AW:0] FULL_MARK = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_MARK = (AW+1)'(DEPTH / 2 + 1);

  always_comb begin
    occ_o    = wptr_i - rptr_i;
    empty_no = (occ_o != '0);
    full_no  = (occ_o != FULL_MARK);
    half_no  = (occ_o < HALF_MARK);
  end

  assert_full_implies_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !half_no);

  assert_empty_full_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!empty_no && !full_no));

  assert_occ_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_o <= FULL_MARK);
endmodule

// File: rtl/rewind_fifo_ram.sv
module rewind_fifo_ram #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [AW-1:0] raddr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          oe_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;
  logic          oe_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= pop_i;
      if (pop_i) rdata_q <= mem[raddr_i];
    end
  end

  // parked at zero stands in for high impedance
  assign rdata_o = oe_q ? rdata_q : '0;
  assign oe_o    = oe_q;

  assert_oe_after_pop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> $past(pop_i));
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic          rt_ni,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_oe_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          half_no
);
  fifo_op_t    op;
  logic [AW:0] wptr, rptr, occ;

  rewind_fifo_ctrl #(.AW(AW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_ni   (wr_ni),
    .rd_ni   (rd_ni),
    .rt_ni   (rt_ni),
    .empty_i (!empty_no),
    .full_i  (!full_no),
    .op_o    (op),
    .wptr_o  (wptr),
    .rptr_o  (rptr)
  );

  rewind_fifo_flags #(.AW(AW)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wptr_i   (wptr),
    .rptr_i   (rptr),
    .occ_o    (occ),
    .empty_no (empty_no),
    .full_no  (full_no),
    .half_no  (half_no)
  );

  rewind_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (op.push),
    .pop_i   (op.pop),
    .waddr_i (wptr[AW-1:0]),
    .raddr_i (rptr[AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .oe_o    (rdata_oe_o)
  );

  assert_pair_keeps_occ_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.push && op.pop) |=> (occ == $past(occ)));

  assert_empty_pop_blocked_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_no) |-> !op.pop);
endmodule

// File: tb/rewind_fifo_bench.sv
module rewind_fifo_bench;
  localparam int DW    = 9;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NV    = 16;

  // {rt_n, wr_n, rd_n, wdata, exp_empty_n, exp_full_n, exp_half_n, exp_oe, exp_rdata}
  localparam logic [24:0] VEC [NV] = '{
    {3'b110, 9'h000, 4'b0110, 9'h000},
    {3'b101, 9'h101, 4'b1110, 9'h000},
    {3'b101, 9'h0AA, 4'b1110, 9'h000},
    {3'b100, 9'h055, 4'b1111, 9'h101},
    {3'b110, 9'h000, 4'b1111, 9'h0AA},
    {3'b111, 9'h000, 4'b1110, 9'h000},
    {3'b110, 9'h000, 4'b0111, 9'h055},
    {3'b100, 9'h1FF, 4'b1110, 9'h000},
    {3'b110, 9'h000, 4'b0111, 9'h1FF},
    {3'b000, 9'h123, 4'b1110, 9'h000},
    {3'b110, 9'h000, 4'b1111, 9'h101},
    {3'b110, 9'h000, 4'b1111, 9'h0AA},
    {3'b101, 9'h0C3, 4'b1110, 9'h000},
    {3'b110, 9'h000, 4'b1111, 9'h055},
    {3'b110, 9'h000, 4'b1111, 9'h1FF},
    {3'b110, 9'h000, 4'b0111, 9'h0C3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          oe, empty_n, full_n, half_n;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  rewind_fifo #(.DW(DW), .AW(AW)) u_rewind_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .rd_ni(rd_n), .rt_ni(rt_n),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(oe),
    .empty_no(empty_n), .full_no(full_n), .half_no(half_n)
  );

  function automatic logic [DW-1:0] dv(input int k);
    return DW'(k * 37 + 5);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic rt, input logic wr, input logic rd, input logic [DW-1:0] d);
    rt_n = rt; wr_n = wr; rd_n = rd; wdata = d;
    @(negedge clk);
    rt_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; wdata = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 flags in reset", 16'({empty_n, full_n, half_n, oe}), 16'b0110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after release", 16'({empty_n, full_n, half_n, oe}), 16'b0110);

    // table: R2/R4/R7/R8/R9/R10/R11/R12
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21:13]);
      n_chk++;
      if ({empty_n, full_n, half_n, oe, rdata} !== VEC[i][12:0]) begin
        n_fail++;
        $display("FAIL table row %0d (R2/R4/R7/R8/R9/R10/R11/R12): actual %h expected %h",
                 i, {empty_n, full_n, half_n, oe, rdata}, VEC[i][12:0]);
      end
    end

    // R1: reset while holding data
    cyc(1'b1, 1'b0, 1'b1, 9'h011);
    cyc(1'b1, 1'b0, 1'b1, 9'h022);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset with data", 16'({empty_n, full_n, half_n, oe}), 16'b0110);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // fill: R5, R6
    for (int k = 0; k < DEPTH; k++) begin
      cyc(1'b1, 1'b0, 1'b1, dv(k));
      chk("R6 half during fill", 16'(half_n), (k + 1 >= DEPTH / 2 + 1) ? 16'd0 : 16'd1);
      chk("R5 full during fill", 16'(full_n), (k + 1 == DEPTH) ? 16'd0 : 16'd1);
    end

    // R3: write while full, then write paired with read while full
    cyc(1'b1, 1'b0, 1'b1, 9'h1EE);
    chk("R3 full stays after ignored write", 16'({full_n, oe}), 16'b00);
    cyc(1'b1, 1'b0, 1'b0, 9'h1DD);
    chk("R3 read at full returns head", 16'(rdata), 16'(dv(0)));
    chk("R3 write at full ignored, occ 15", 16'({full_n, half_n}), 16'b10);

    // drain: R2 order, R6 boundary, R12 empty
    for (int k = 1; k < DEPTH; k++) begin
      cyc(1'b1, 1'b1, 1'b0, '0);
      chk("R2 drain order", 16'({oe, rdata}), 16'({1'b1, dv(k)}));
      chk("R6 half during drain", 16'(half_n), (DEPTH - 1 - k >= DEPTH / 2 + 1) ? 16'd0 : 16'd1);
    end
    chk("R12 empty after drain", 16'(empty_n), 16'd0);

    // R4: read on empty, then pointer still aligned
    cyc(1'b1, 1'b1, 1'b0, '0);
    chk("R4 read on empty", 16'({empty_n, oe, rdata}), 16'd0);
    cyc(1'b1, 1'b1, 1'b1, '0);
    chk("R10 idle keeps output parked", 16'({oe, rdata}), 16'd0);
    cyc(1'b1, 1'b0, 1'b1, dv(40));
    cyc(1'b1, 1'b1, 1'b0, '0);
    chk("R4 next read after ignored one", 16'({oe, rdata}), 16'({1'b1, dv(40)}));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule